// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software liveness in two escalating steps. A first-stage counter runs while software stays quiet. If no service strobe arrives within the first-stage period, the block raises a one-cycle non-maskable interrupt request and latches a stage-1 status flag. It then starts a second countdown. If software still does not service the watchdog before that countdown ends, and the reset stage is armed, the block drives its reset output for a fixed number of cycles. It also latches a stage-2 status flag and disarms the reset stage.

Software reaches the block through a single byte-wide control/status register on a small address/write-enable/data port. The two status flags are sticky. Software clears a flag by writing 0 to its bit, and writing 1 to it does nothing. The system hard reset clears the stage-1 flag and the arm bit. It preserves the stage-2 flag when a companion input says the reset came from the watchdog itself, so software can find out after reboot why the system restarted. All periods are parameters counted in clock cycles.

Top module: `wdg_two_stage`

## Requirements
- R1: While `rst` is high with `rst_by_wdog` low, and in the first cycle after it falls, the control byte reads 0x00 and both `nmi_o` and `wdog_rst_o` are low.
- R2: If no kick is sampled for STAGE1_CYCLES consecutive edges after the last kick (or reset), `nmi_o` is high for exactly one cycle following the STAGE1_CYCLES-th edge. From that cycle on, bit 6 of the control byte reads 1.
- R3: Kicks spaced closer than STAGE1_CYCLES edges apart prevent any `nmi_o` pulse.
- R4: With bit 5 (arm) set, `wdog_rst_o` rises STAGE2_DELAY_CYCLES edges after `nmi_o` rises and stays high for exactly RESET_PULSE_CYCLES cycles. From its first high cycle, bit 7 reads 1.
- R5: With bit 5 clear when the second-stage delay ends, `wdog_rst_o` stays low and bit 7 stays 0. The first stage restarts, so the next `nmi_o` rises STAGE2_DELAY_CYCLES + STAGE1_CYCLES edges after the previous one.
- R6: A kick during the second-stage countdown cancels it: no reset pulse follows and bit 7 stays 0.
- R7: Bits 7 and 6 are sticky. A register write with 0 in a bit clears it, a write with 1 leaves it unchanged, and only a watchdog event sets it.
- R8: Bits 4..0 of the control byte always read 0. `reg_rdata` is 0 when `reg_addr` differs from CTRL_ADDR, and writes to any other address change nothing.
- R9: A hard reset clears bits 6 and 5. It also clears bit 7 when `rst_by_wdog` is low, and keeps bit 7 when it is high.
- R10: When the reset pulse starts, bit 5 reads 0. A later escalation produces no further reset pulse until software sets bit 5 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| rst_by_wdog | input | 1 | Qualifies `rst`: high when the hard reset came from this watchdog |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| kick | input | 1 | Service strobe from software |
| nmi_o | output | 1 | One-cycle first-stage interrupt request |
| wdog_rst_o | output | 1 | Second-stage reset pulse |

## Verification
The bench builds the block with STAGE1_CYCLES = 20, STAGE2_DELAY_CYCLES = 12 and RESET_PULSE_CYCLES = 4. At these values a full escalation, a disarmed escalation with stage-1 restart, and the re-escalation after the arm bit has dropped each complete within a few dozen cycles, and every edge can be counted exactly. It uses ADDR_W = 4 with the register at address 3, which leaves a second address to show that decoding rejects foreign reads and writes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_MON2 = 7;
    localparam int unsigned BIT_MON1 = 6;
    localparam int unsigned BIT_ARM  = 5;

    typedef enum logic [1:0] {
        ESC_RUN  = 2'd0,
        ESC_WAIT = 2'd1,
        ESC_HOLD = 2'd2
    } esc_state_e;

    typedef struct packed {
        logic mon2;
        logic mon1;
        logic arm;
    } wdg_ctrl_t;

    typedef struct packed {
        logic wr;
        logic clr_mon2;
        logic clr_mon1;
        logic arm_val;
    } wdg_wr_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_byte(input wdg_ctrl_t c);
        logic [REG_W-1:0] b;
        b           = '0;
        b[BIT_MON2] = c.mon2;
        b[BIT_MON1] = c.mon1;
        b[BIT_ARM]  = c.arm;
        return b;
    endfunction

    function automatic wdg_wr_t decode_write(input logic wr,
                                             input logic m2,
                                             input logic m1,
                                             input logic a);
        wdg_wr_t w;
        w.wr       = wr;
        w.clr_mon2 = wr & ~m2;
        w.clr_mon1 = wr & ~m1;
        w.arm_val  = a;
        return w;
    endfunction

endpackage

// File: rtl/wdg_stage1_timer.sv
module wdg_stage1_timer #(
    parameter int unsigned PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int unsigned W    = wdg_pkg::cnt_width(PERIOD);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    // Counter is held at zero outside the run phase and on every kick.
    always_ff @(posedge clk) begin
        if (rst || kick || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && !kick && (cnt_q == LAST);

endmodule

// File: rtl/wdg_escalator.sv
module wdg_escalator
    import wdg_pkg::*;
#(
    parameter int unsigned DELAY = 8,
    parameter int unsigned HOLD  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire1,
    input  logic       kick,
    input  logic       arm,
    output esc_state_e state_o,
    output logic       nmi_o,
    output logic       fire_o,
    output logic       rst_o
);
    localparam int unsigned SPAN = (DELAY > HOLD) ? DELAY : HOLD;
    localparam int unsigned W    = cnt_width(SPAN);
    localparam logic [W-1:0] WAIT_LAST = W'(DELAY - 1);
    localparam logic [W-1:0] HOLD_LAST = W'(HOLD - 1);

    esc_state_e state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         nmi_q;
    logic         fire;

    // One counter times both the escalation delay and the reset hold.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        fire    = 1'b0;
        unique case (state_q)
            ESC_RUN: begin
                cnt_d = '0;
                if (expire1) state_d = ESC_WAIT;
            end
            ESC_WAIT: begin
                if (kick) begin
                    state_d = ESC_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == WAIT_LAST) begin
                    cnt_d = '0;
                    if (arm) begin
                        state_d = ESC_HOLD;
                        fire    = 1'b1;
                    end else begin
                        state_d = ESC_RUN;
                    end
                end
            end
            ESC_HOLD: begin
                if (cnt_q == HOLD_LAST) begin
                    state_d = ESC_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ESC_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ESC_RUN;
            cnt_q   <= '0;
            nmi_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            nmi_q   <= expire1;
        end
    end

    assign state_o = state_q;
    assign nmi_o   = nmi_q;
    assign fire_o  = fire;
    assign rst_o   = (state_q == ESC_HOLD);

endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rst_by_wdog,
    input  wdg_wr_t   wr,
    input  logic      set_mon1,
    input  logic      fire,
    output wdg_ctrl_t ctrl_o
);
    wdg_ctrl_t ctrl_q;

    // Hardware events win over a software write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mon1 <= 1'b0;
            ctrl_q.arm  <= 1'b0;
            if (!rst_by_wdog) ctrl_q.mon2 <= 1'b0;
        end else begin
            if (fire)              ctrl_q.mon2 <= 1'b1;
            else if (wr.clr_mon2)  ctrl_q.mon2 <= 1'b0;

            if (set_mon1)          ctrl_q.mon1 <= 1'b1;
            else if (wr.clr_mon1)  ctrl_q.mon1 <= 1'b0;

            if (fire)              ctrl_q.arm  <= 1'b0;
            else if (wr.wr)        ctrl_q.arm  <= wr.arm_val;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage
    import wdg_pkg::*;
#(
    parameter int unsigned          ADDR_W              = 4,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR           = '0,
    parameter int unsigned          STAGE1_CYCLES       = 50_000_000,
    parameter int unsigned          STAGE2_DELAY_CYCLES = 12_500_000,
    parameter int unsigned          RESET_PULSE_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_by_wdog,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              kick,
    output logic              nmi_o,
    output logic              wdog_rst_o
);
    logic       sel;
    wdg_wr_t    wr_s;
    wdg_ctrl_t  ctrl_q;
    esc_state_e esc_state;
    logic       run;
    logic       expire1;
    logic       fire;

    assign sel  = (reg_addr == CTRL_ADDR);
    assign wr_s = decode_write(reg_we && sel, reg_wdata[BIT_MON2],
                               reg_wdata[BIT_MON1], reg_wdata[BIT_ARM]);
    assign reg_rdata = sel ? ctrl_to_byte(ctrl_q) : '0;
    assign run  = (esc_state == ESC_RUN);

    wdg_stage1_timer #(
        .PERIOD (STAGE1_CYCLES)
    ) u_stage1 (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .kick   (kick),
        .expire (expire1)
    );

    wdg_escalator #(
        .DELAY (STAGE2_DELAY_CYCLES),
        .HOLD  (RESET_PULSE_CYCLES)
    ) u_esc (
        .clk     (clk),
        .rst     (rst),
        .expire1 (expire1),
        .kick    (kick),
        .arm     (ctrl_q.arm),
        .state_o (esc_state),
        .nmi_o   (nmi_o),
        .fire_o  (fire),
        .rst_o   (wdog_rst_o)
    );

    wdg_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rst_by_wdog (rst_by_wdog),
        .wr          (wr_s),
        .set_mon1    (expire1),
        .fire        (fire),
        .ctrl_o      (ctrl_q)
    );

endmodule

// File: rtl/wdg_two_stage_chk.sv
module wdg_two_stage_chk (
    input logic clk,
    input logic rst,
    input logic nmi_o,
    input logic wdog_rst_o,
    input logic mon1,
    input logic mon2,
    input logic arm,
    input logic clr1,
    input logic clr2
);
    AST_NMI_SINGLE:  assert property (@(posedge clk) disable iff (rst)
        nmi_o |=> !nmi_o);                                   // R2
    AST_NMI_FLAGS:   assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> mon1);                                     // R2
    AST_MON1_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mon1 && !clr1) |=> mon1);                           // R7
    AST_MON2_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mon2 && !clr2) |=> mon2);                           // R7
    AST_MON1_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(mon1) |-> nmi_o);                              // R7
    AST_RST_ARMED:   assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_rst_o) |-> ($past(arm) && mon2 && !arm)); // R4 R10
    AST_MON2_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(mon2) |-> $rose(wdog_rst_o));                  // R5
endmodule

bind wdg_two_stage wdg_two_stage_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .nmi_o      (nmi_o),
    .wdog_rst_o (wdog_rst_o),
    .mon1       (ctrl_q.mon1),
    .mon2       (ctrl_q.mon2),
    .arm        (ctrl_q.arm),
    .clr1       (reg_we && (reg_addr == CTRL_ADDR) && !reg_wdata[6]),
    .clr2       (reg_we && (reg_addr == CTRL_ADDR) && !reg_wdata[7])
);

// File: tb/tb_wdg_two_stage.sv
module tb_wdg_two_stage;
    localparam int unsigned S1 = 20;
    localparam int unsigned S2 = 12;
    localparam int unsigned RP = 4;
    localparam logic [3:0]  CA = 4'h3;
    localparam logic [3:0]  OA = 4'h5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_by_wdog = 1'b0;
    logic [3:0] reg_addr = CA;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       kick = 1'b0;
    logic       nmi_o;
    logic       wdog_rst_o;

    int total = 0;
    int bad = 0;
    int nmi_seen = 0;
    int rst_seen = 0;

    always #10 clk = ~clk;

    wdg_two_stage #(
        .ADDR_W              (4),
        .CTRL_ADDR           (CA),
        .STAGE1_CYCLES       (S1),
        .STAGE2_DELAY_CYCLES (S2),
        .RESET_PULSE_CYCLES  (RP)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .rst_by_wdog (rst_by_wdog),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .kick        (kick),
        .nmi_o       (nmi_o),
        .wdog_rst_o  (wdog_rst_o)
    );

    always @(negedge clk) begin
        if (nmi_o)      nmi_seen++;
        if (wdog_rst_o) rst_seen++;
    end

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic rd(output logic [7:0] v);
        reg_addr = CA;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        step();
        reg_we    = 1'b0;
        reg_addr  = CA;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        step();
        kick = 1'b0;
    endtask

    task automatic hard_reset(input logic cause);
        rst = 1'b1;
        rst_by_wdog = cause;
        step();
        step();
        rst = 1'b0;
        rst_by_wdog = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        rd(v);
        chk("R1 reset byte", v, 8'h00);
        chk("R1 reset nmi", nmi_o, 0);
        chk("R1 reset rst_o", wdog_rst_o, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_kick();
        wr(CA, 8'hFF);
        rd(v);
        chk("R8 low bits zero, arm set", v, 8'h20);
        wr(OA, 8'h00);
        rd(v);
        chk("R8 foreign write ignored", v, 8'h20);
        reg_addr = OA;
        #1;
        chk("R8 foreign read zero", reg_rdata, 8'h00);
        wr(CA, 8'h1F);
        rd(v);
        chk("R8 arm cleared, low bits zero", v, 8'h00);
    endtask

    task automatic t_kick_hold();
        int n0 = nmi_seen;
        for (int i = 0; i < 6; i++) begin
            do_kick();
            repeat (S1 - 3) step();
        end
        chk("R3 no nmi while kicked", nmi_seen - n0, 0);
    endtask

    task automatic t_disarmed();
        logic [7:0] v;
        int r0;
        do_kick();
        r0 = rst_seen;
        repeat (S1 - 1) step();
        chk("R2 nmi not early", nmi_o, 0);
        step();
        chk("R2 nmi at period", nmi_o, 1);
        rd(v);
        chk("R2 stage1 flag", v, 8'h40);
        step();
        chk("R2 nmi single cycle", nmi_o, 0);
        repeat (S2 - 1) step();
        chk("R5 no reset when disarmed", wdog_rst_o, 0);
        rd(v);
        chk("R5 stage2 flag stays 0", v, 8'h40);
        repeat (S1 - 1) step();
        chk("R5 restart nmi not early", nmi_o, 0);
        step();
        chk("R5 restart nmi timing", nmi_o, 1);
        do_kick();
        chk("R5 no reset pulse seen", rst_seen - r0, 0);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        do_kick();
        wr(CA, 8'hC0);
        rd(v);
        chk("R7 write 1 keeps flag", v, 8'h40);
        wr(CA, 8'h80);
        rd(v);
        chk("R7 write 0 clears flag", v, 8'h00);
    endtask

    task automatic t_armed();
        logic [7:0] v;
        int r0;
        wr(CA, 8'h20);
        do_kick();
        repeat (S1) step();
        chk("R4 nmi before reset", nmi_o, 1);
        repeat (S2 - 1) step();
        chk("R4 reset not early", wdog_rst_o, 0);
        step();
        chk("R4 reset at delay", wdog_rst_o, 1);
        r0 = rst_seen;
        rd(v);
        chk("R4 R10 flags and disarm", v, 8'hC0);
        repeat (RP - 1) step();
        chk("R4 reset still held", wdog_rst_o, 1);
        step();
        chk("R4 reset pulse length", wdog_rst_o, 0);
        repeat (S1) step();
        chk("R10 escalates again", nmi_o, 1);
        repeat (S2 + RP + 2) step();
        chk("R10 no second reset", rst_seen - r0, RP - 1);
        rd(v);
        chk("R10 arm stays 0", v, 8'hC0);
        do_kick();
    endtask

    task automatic t_hard_reset();
        logic [7:0] v;
        wr(CA, 8'hE0);
        rd(v);
        chk("R7 write 1 keeps stage2 flag", v, 8'hE0);
        hard_reset(1'b1);
        rd(v);
        chk("R9 watchdog reset keeps bit7", v, 8'h80);
        hard_reset(1'b0);
        rd(v);
        chk("R9 other reset clears all", v, 8'h00);
    endtask

    task automatic t_cancel();
        logic [7:0] v;
        int r0;
        wr(CA, 8'h20);
        do_kick();
        repeat (S1) step();
        chk("R6 nmi raised", nmi_o, 1);
        repeat (3) step();
        do_kick();
        r0 = rst_seen;
        repeat (S2 + RP + 2) step();
        chk("R6 kick cancels reset", rst_seen - r0, 0);
        rd(v);
        chk("R6 stage2 flag stays 0", v, 8'h60);
        wr(CA, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements) act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_kick_hold();
        t_disarmed();
        t_sticky();
        t_armed();
        t_hard_reset();
        t_cancel();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule